// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Bit-Clock Selection

This block serialises bytes onto a single idle-high line. It contains its own bit-clock generator. A write-only configuration word controls it: a transmit enable, a receive enable kept for a companion receiver, the number of stop bits, a parity enable with its type, and a 3-bit bit-clock selector. The selector picks one of six power-of-two multiples of a base divider, a separate fixed divider, or an external timer pulse.

Bytes enter through a valid/ready port backed by a single-entry holding buffer. The port is ready exactly when the buffer is empty. A byte is taken on any cycle where `in_valid` and `in_ready` are both high. Once taken, it blocks further bytes until the frame engine moves it into the shift register, and that happens on a bit-clock tick. While transmission is disabled, a taken byte is only parked: it is never queued for sending, and the port stays ready. A one-cycle done pulse marks the end of every frame.

The bit-clock tick, the parity settings and the receive enable are exported so that a receiver can share them.

Top module: `uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` and `tx_buf_empty` are 1, `tx_done` is 0, and all configuration fields are 0: transmit and receive disabled, one stop bit, no parity, clock select 0.
- R2: A frame is made of these bits, in order, and the line is 1 between frames:
  - a start bit of 0;
  - the 8 data bits, least significant first;
  - the optional parity bit;
  - the stop bits, each 1.
- R3: Every bit lasts exactly one bit-clock period. Clock-select codes 0 to 5 give 13, 26, 52, 104, 208 and 416 system clocks per bit. Code 7 gives 96.
- R4: With clock-select code 6, each bit lasts from one `ext_tick` pulse to the next.
- R5: The parity bit is controlled by configuration bits 3 and 4.
  - When bit 3 of the configuration word is 1, a parity bit follows the data. When it is 0, no parity bit is sent.
  - Bit 4 selects odd parity when 0 and even parity when 1. The parity bit makes the total count of ones over the data and parity bits odd or even.
- R6: Configuration bit 2 set to 1 gives two stop bits. Set to 0, it gives one.
- R7: The configuration word is laid out as follows: bit 0 is transmit enable, bit 1 is receive enable, and bits 7:5 are clock select. A write to bits 7:5 is ignored while the stored transmit or receive enable is 1. The other fields are always written.
- R8: Clearing the transmit enable during a frame lets that frame finish unchanged. No further frame starts after it.
- R9: A byte taken while transmission is disabled is not sent when transmission is later enabled. Only a byte written after enabling is sent.
- R10: Back-pressure on the input port works as follows:
  - While enabled, taking a byte drops `in_ready` and `tx_buf_empty`.
  - Both rise again when the byte moves into the shift register, which happens at the tick that begins its start bit.
  - A byte waiting at the end of a frame starts at the same tick, with no idle gap.
- R11: `tx_done` is high for exactly one cycle, starting one frame length (in system clocks) after the start bit began.
- R12: `bit_tick` pulses once per bit period of the selected clock. `par_en_o`, `par_even_o` and `rx_en_o` follow the stored configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word, see R5 to R7 |
| ext_tick | input | 1 | External timer pulse used with clock select 6 |
| in_valid | input | 1 | Byte offered on in_data |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Holding buffer can take a byte |
| txd | output | 1 | Serial output, idle high |
| tx_buf_empty | output | 1 | Holding buffer is empty |
| tx_done | output | 1 | One-cycle pulse at frame end |
| bit_tick | output | 1 | Shared bit-clock tick |
| par_en_o | output | 1 | Shared parity enable |
| par_even_o | output | 1 | Shared parity type, 1 means even |
| rx_en_o | output | 1 | Stored receive enable |

## Verification
Frames are timed at the line, so a wrong divisor entry drifts the mid-bit samples. A missing or wrong-polarity parity bit shows up as a bit mismatch, and an extra stop bit moves the done pulse later. Clock-select writes are tried with an enable set; a design that accepts them stretches the next frame to the new divider. The transmit enable is cleared mid-frame, and a byte is parked while disabled. A design that aborts, keeps sending, or releases the stale byte on enabling produces a truncated frame or a spurious start bit. Two bytes are pushed back to back to check that the port stalls for a whole frame and that the second start bit follows the last stop bit with no gap.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // configuration word layout (bit 0 = transmit enable ... bits 7:5 = clock select)
  typedef struct packed {
    logic [2:0] clk_sel;
    logic       par_even;
    logic       par_en;
    logic       stop2;
    logic       rx_en;
    logic       tx_en;
  } tx_cfg_t;

  localparam int CFG_W = $bits(tx_cfg_t);

  localparam logic [2:0] SEL_EXT = 3'd6;
  localparam logic [2:0] SEL_ALT = 3'd7;

  function automatic logic parity_of(input logic [7:0] d, input logic even);
    return even ? (^d) : ~(^d);
  endfunction

endpackage

// File: rtl/uart_tx_cfg.sv
module uart_tx_cfg
  import uart_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output tx_cfg_t          cfg
);

  tx_cfg_t cfg_q;
  tx_cfg_t new_w;
  logic    sel_locked;

  assign new_w      = tx_cfg_t'(wdata);
  assign sel_locked = cfg_q.tx_en | cfg_q.rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr) begin
      cfg_q.tx_en    <= new_w.tx_en;
      cfg_q.rx_en    <= new_w.rx_en;
      cfg_q.stop2    <= new_w.stop2;
      cfg_q.par_en   <= new_w.par_en;
      cfg_q.par_even <= new_w.par_even;
      if (!sel_locked) cfg_q.clk_sel <= new_w.clk_sel;
    end
  end

  assign cfg = cfg_q;

  // R7: selector frozen while any enable is stored
  p_sel_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (cfg.tx_en || cfg.rx_en)) |=> $stable(cfg.clk_sel));

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
  import uart_tx_pkg::*;
#(
  parameter int BASE_DIV = 13,
  parameter int ALT_DIV  = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       ext_tick,
  output logic       tick
);

  localparam int MAX_DIV = (BASE_DIV * 32 > ALT_DIV) ? BASE_DIV * 32 : ALT_DIV;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_m1;
  logic [2:0]       sel_q;
  logic             use_ext;
  logic             wrap;

  assign use_ext = (sel == SEL_EXT);

  always_comb begin
    if (sel == SEL_ALT)   lim_m1 = CNT_W'(ALT_DIV - 1);
    else if (use_ext)     lim_m1 = '0;
    else                  lim_m1 = CNT_W'((BASE_DIV << sel) - 1);
  end

  assign wrap = (cnt_q == lim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      sel_q <= sel;
      if (sel != sel_q || use_ext || wrap) cnt_q <= '0;
      else                                 cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tick = use_ext ? ext_tick : (wrap && sel == sel_q);

  // R3: internal dividers never tick on consecutive cycles
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !use_ext) |=> !tick);

endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              pending,
  output logic [DATA_W-1:0] data
);

  logic              pend_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign accept = in_valid && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) data_q <= in_data;
      if (!tx_en)      pend_q <= 1'b0;
      else if (accept) pend_q <= 1'b1;
      else if (take)   pend_q <= 1'b0;
    end
  end

  assign in_ready = !pend_q;
  assign pending  = pend_q;
  assign data     = data_q;

  // R10: an enabled accept fills the buffer
  p_accept_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && tx_en) |=> !in_ready);
  // R10: moving the byte into the shifter frees the buffer
  p_take_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> in_ready);
  // R9: a parked byte never becomes pending while disabled
  p_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> in_ready);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_ok,
  input  logic [DATA_W-1:0] data,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              stop2,
  output logic              take,
  output logic              txd,
  output logic              done
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   rem_q;
  logic [LEN_W-1:0]   len;
  logic               busy_q;
  logic               done_q;
  logic               last;

  always_comb begin
    frame              = '1;
    frame[0]           = 1'b0;
    frame[DATA_W:1]    = data;
    if (par_en) frame[DATA_W+1] = parity_of(data, par_even);
  end

  assign len  = LEN_W'(DATA_W + 2) + LEN_W'(par_en) + LEN_W'(stop2);
  assign last = busy_q && (rem_q == LEN_W'(1));
  assign take = tick && start_ok && (!busy_q || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      rem_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        if (last) done_q <= 1'b1;
        if (take) begin
          shreg_q <= frame;
          rem_q   <= len;
          busy_q  <= 1'b1;
        end else if (last) begin
          busy_q  <= 1'b0;
          shreg_q <= '1;
        end else if (busy_q) begin
          shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
          rem_q   <= rem_q - LEN_W'(1);
        end
      end
    end
  end

  assign txd  = busy_q ? shreg_q[0] : 1'b1;
  assign done = done_q;

  // R3: the line only moves right after a bit-clock tick
  p_line_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));
  // R2: every frame begins with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !txd);
  // R11: done is a single-cycle pulse
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BASE_DIV = 13,
  parameter int ALT_DIV  = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              ext_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic              tx_buf_empty,
  output logic              tx_done,
  output logic              bit_tick,
  output logic              par_en_o,
  output logic              par_even_o,
  output logic              rx_en_o
);

  tx_cfg_t           cfg;
  logic              tick;
  logic              take;
  logic              pending;
  logic [DATA_W-1:0] buf_data;
  logic              rdy;

  uart_tx_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  uart_tx_baud #(.BASE_DIV(BASE_DIV), .ALT_DIV(ALT_DIV)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (cfg.clk_sel),
    .ext_tick (ext_tick),
    .tick     (tick)
  );

  uart_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (cfg.tx_en),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (rdy),
    .take     (take),
    .pending  (pending),
    .data     (buf_data)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start_ok (pending && cfg.tx_en),
    .data     (buf_data),
    .par_en   (cfg.par_en),
    .par_even (cfg.par_even),
    .stop2    (cfg.stop2),
    .take     (take),
    .txd      (txd),
    .done     (tx_done)
  );

  assign in_ready     = rdy;
  assign tx_buf_empty = rdy;
  assign bit_tick     = tick;
  assign par_en_o     = cfg.par_en;
  assign par_even_o   = cfg.par_even;
  assign rx_en_o      = cfg.rx_en;

  // R8: a disabled block never starts a frame
  p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.tx_en |-> !take);

endmodule

// File: tb/uart_tx_test.sv
`timescale 1ns/1ps
module uart_tx_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       ext_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, txd, tx_buf_empty, tx_done, bit_tick, par_en_o, par_even_o, rx_en_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [2:0] cur_sel = 3'd0;
  logic ext_on = 1'b0;
  int ext_cnt = 0;
  localparam int EXT_P = 20;

  always #5 clk = ~clk;

  uart_tx uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ext_tick(ext_tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd), .tx_buf_empty(tx_buf_empty),
    .tx_done(tx_done), .bit_tick(bit_tick), .par_en_o(par_en_o),
    .par_even_o(par_even_o), .rx_en_o(rx_en_o)
  );

  always @(negedge clk) begin
    if (ext_on) begin
      ext_cnt  = (ext_cnt + 1) % EXT_P;
      ext_tick = (ext_cnt == 0);
    end else begin
      ext_tick = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [2:0] sel, input logic ev, input logic pe,
                                    input logic st2, input logic rx, input logic tx);
    return {sel, ev, pe, st2, rx, tx};
  endfunction

  task automatic cfg_write(input logic [7:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] sel, input logic pe, input logic ev, input logic st2);
    cfg_write(mk(cur_sel, ev, pe, st2, 1'b0, 1'b0));
    cfg_write(mk(sel, ev, pe, st2, 1'b0, 1'b0));
    cfg_write(mk(sel, ev, pe, st2, 1'b0, 1'b1));
    cur_sel = sel;
    ext_on  = (sel == 3'd6);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // waits for the start bit, checks every bit mid-period and the done timing
  task automatic check_frame(input logic [7:0] d, input int div, input logic pe,
                             input logic ev, input logic st2, input string req);
    logic exp_bits[12];
    int n;
    int t;
    n = 10 + int'(pe) + int'(st2);
    exp_bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) exp_bits[i+1] = d[i];
    for (int i = 9; i < 12; i++) exp_bits[i] = 1'b1;
    if (pe) exp_bits[9] = ev ? ^d : ~^d;
    t = 0;
    while (txd !== 1'b0 && t < 40 * div) begin @(negedge clk); t++; end
    chk(txd === 1'b0, {req, " start bit seen"}, int'(txd), 0);
    for (int k = 0; k <= n * div; k++) begin
      if (k > 0) @(negedge clk);
      if (k < n * div && (k % div) == div / 2)
        chk(txd === exp_bits[k / div], {req, " frame bit"}, int'(txd), int'(exp_bits[k / div]));
      if (k < n * div && tx_done === 1'b1)
        chk(1'b0, {req, " early done (R11)"}, k, n * div);
    end
    chk(tx_done === 1'b1, {req, " done at frame end (R11)"}, int'(tx_done), 1);
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
    chk(in_ready === 1'b1 && tx_buf_empty === 1'b1, "R1 buffer empty", int'(in_ready), 1);
    chk(tx_done === 1'b0, "R1 done low", int'(tx_done), 0);
    chk({par_en_o, par_even_o, rx_en_o} === 3'b000, "R1 config zero",
        int'({par_en_o, par_even_o, rx_en_o}), 0);
  endtask

  task automatic t_tick_and_exports;
    int gap;
    while (bit_tick !== 1'b1) @(negedge clk);
    gap = 0;
    do begin @(negedge clk); gap++; end while (bit_tick !== 1'b1 && gap < 100);
    chk(gap == 13, "R12 bit_tick spacing for code 0 (R3)", gap, 13);
    cfg_write(mk(3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    @(negedge clk);
    chk({par_en_o, par_even_o, rx_en_o} === 3'b111, "R12 exported settings",
        int'({par_en_o, par_even_o, rx_en_o}), 7);
    cfg_write(mk(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  task automatic t_basic;
    set_mode(3'd0, 1'b0, 1'b0, 1'b0);
    send(8'hA5);
    check_frame(8'hA5, 13, 1'b0, 1'b0, 1'b0, "R2 R3 code0 A5");
    @(negedge clk);
    chk(tx_done === 1'b0, "R11 done single cycle", int'(tx_done), 0);
    chk(txd === 1'b1, "R2 idle high after frame", int'(txd), 1);
    send(8'h3C);
    check_frame(8'h3C, 13, 1'b0, 1'b0, 1'b0, "R2 code0 3C");
  endtask

  task automatic t_dividers;
    set_mode(3'd3, 1'b0, 1'b0, 1'b0);
    send(8'h96);
    check_frame(8'h96, 104, 1'b0, 1'b0, 1'b0, "R3 code3 div104");
    set_mode(3'd7, 1'b0, 1'b0, 1'b0);
    send(8'h01);
    check_frame(8'h01, 96, 1'b0, 1'b0, 1'b0, "R3 code7 div96");
    set_mode(3'd1, 1'b0, 1'b0, 1'b0);
    send(8'hF0);
    check_frame(8'hF0, 26, 1'b0, 1'b0, 1'b0, "R3 code1 div26");
  endtask

  task automatic t_parity;
    set_mode(3'd0, 1'b1, 1'b0, 1'b0);
    send(8'h07);
    check_frame(8'h07, 13, 1'b1, 1'b0, 1'b0, "R5 odd parity");
    set_mode(3'd0, 1'b1, 1'b1, 1'b0);
    send(8'h07);
    check_frame(8'h07, 13, 1'b1, 1'b1, 1'b0, "R5 even parity");
    send(8'h33);
    check_frame(8'h33, 13, 1'b1, 1'b1, 1'b0, "R5 even parity 33");
  endtask

  task automatic t_stop2;
    set_mode(3'd0, 1'b0, 1'b0, 1'b1);
    send(8'hC3);
    check_frame(8'hC3, 13, 1'b0, 1'b0, 1'b1, "R6 two stop bits");
    set_mode(3'd0, 1'b1, 1'b0, 1'b1);
    send(8'h5E);
    check_frame(8'h5E, 13, 1'b1, 1'b0, 1'b1, "R6 R5 parity and two stops");
  endtask

  task automatic t_ext;
    set_mode(3'd6, 1'b0, 1'b0, 1'b0);
    send(8'h6B);
    check_frame(8'h6B, EXT_P, 1'b0, 1'b0, 1'b0, "R4 external tick");
  endtask

  task automatic t_lock;
    set_mode(3'd0, 1'b0, 1'b0, 1'b0);
    cfg_write(mk(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    send(8'h2D);
    check_frame(8'h2D, 13, 1'b0, 1'b0, 1'b0, "R7 select write ignored while enabled");
  endtask

  task automatic t_disable_mid;
    int hi;
    set_mode(3'd0, 1'b0, 1'b0, 1'b0);
    send(8'h5A);
    fork
      check_frame(8'h5A, 13, 1'b0, 1'b0, 1'b0, "R8 frame completes after disable");
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (40) @(negedge clk);
        cfg_write(mk(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      end
    join
    send(8'h00);
    hi = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); if (txd === 1'b1) hi++; end
    chk(hi == 300, "R8 no frame while disabled", hi, 300);
  endtask

  task automatic t_stale;
    int hi;
    cfg_write(mk(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    send(8'h0F);
    chk(tx_buf_empty === 1'b1, "R9 parked byte leaves port ready", int'(tx_buf_empty), 1);
    cfg_write(mk(3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    hi = 0;
    for (int k = 0; k < 400; k++) begin @(negedge clk); if (txd === 1'b1) hi++; end
    chk(hi == 400, "R9 stale byte not sent on enable", hi, 400);
    send(8'h81);
    check_frame(8'h81, 13, 1'b0, 1'b0, 1'b0, "R9 fresh byte sent");
  endtask

  task automatic t_backpressure;
    int k;
    set_mode(3'd0, 1'b0, 1'b0, 1'b0);
    send(8'h11);
    fork
      check_frame(8'h11, 13, 1'b0, 1'b0, 1'b0, "R10 first of pair");
      begin
        send(8'hEE);
        chk(in_ready === 1'b0 && tx_buf_empty === 1'b0, "R10 stall while buffer full",
            int'(in_ready), 0);
      end
    join
    chk(txd === 1'b0, "R10 second start follows last stop", int'(txd), 0);
    chk(in_ready === 1'b1, "R10 ready after move to shifter", int'(in_ready), 1);
    k = 0;
    do begin @(negedge clk); k++; end while (tx_done !== 1'b1 && k < 1000);
    chk(k == 130, "R11 R10 second frame length", k, 130);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick_and_exports();
    t_basic();
    t_dividers();
    t_parity();
    t_stop2();
    t_ext();
    t_lock();
    t_disable_mid();
    t_stale();
    t_backpressure();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule